// File: doc/BRIEF.md
# Interleaving Reed-Solomon Encoder with Selectable Check Length

This block is a systematic Reed-Solomon encoder over GF(2^8), built on the field polynomial x^8 + x^4 + x^3 + x^2 + 1 (low byte 0x1D once x^8 is dropped). It takes one data byte per clock. Each byte goes to the output one cycle later, unchanged. After the last data byte of a block, the block emits the check bytes.

The number of check bytes per codeword is chosen per block from {2, 3, 4, 6, 8}. The generator is the product of (x + α^i) for i = 0 up to c−1, where α = 0x02.

Up to four codewords can be interleaved. Consecutive data bytes go to codeword ways 0 through D−1 in turn, and each way has its own parity register. The check bytes leave in the same rotation: for each degree, from the highest down, one byte is taken from each way in order. A codeword may hold at most 255 bytes.

Top module: `rs_interleave_enc`

## Requirements
- R1: After reset, `out_valid`, `out_chk` and `out_last` are 0 and `in_ready` is 1.
- R2: A data byte accepted in a cycle (`in_valid` and `in_ready` both high) appears on `out_data` in the next cycle, with `out_valid`=1 and `out_chk`=0.
- R3: Form each codeword from its data bytes in arrival order, followed by its check bytes in emission order, with the first byte as the highest-degree coefficient. Every such codeword evaluates to zero at α^0 … α^(c−1), where α=0x02 in the field reduced by 0x11D.
- R4: `cfg_chk_sel` selects the check count c as follows: 0→2, 1→3, 2→4, 3→6, and 4 to 7→8.
- R5: `cfg_ways` gives the depth D−1. Data byte i of a block belongs to way i mod D. The check bytes are emitted grouped by degree, highest degree first, with ways 0 to D−1 in order inside each group.
- R6: The configuration is taken from the first accepted byte of a block. Changes to `cfg_chk_sel` or `cfg_ways` later in the same block have no effect.
- R7: After the byte marked `in_last` is accepted, `in_ready` is low for exactly D·c cycles, and exactly D·c check bytes are emitted on consecutive cycles. Bytes offered during that time are not accepted and do not appear at the output.
- R8: `out_last` is 1 on the final check byte of a block and on no other output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chk_sel | input | 3 | Check-count select code (R4) |
| cfg_ways | input | $clog2(MAX_WAYS) | Interleave depth minus one |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input data byte |
| in_last | input | 1 | Marks the last data byte of a block |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Passed data byte or check byte |
| out_chk | output | 1 | Output byte is a check byte |
| out_last | output | 1 | Final check byte of the block |

## Verification
The assertions assume two things about the source. First, every block holds a whole number of rows, so the byte marked last always lands on way D−1. Second, each way carries no more than 255−c data bytes. The bench generates only blocks of this shape, with 1, 5 or the maximum number of bytes per way. It keeps `in_valid` high with junk data and `in_last` set while check bytes drain, so that any wrongly accepted byte would corrupt the observed stream. It also changes the configuration inputs after the first byte of every block, to show that mid-block changes are ignored.

// File: rtl/rs_interleave_enc.sv
module rs_interleave_enc #(
  parameter int MAX_WAYS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    cfg_chk_sel,
  input  logic [$clog2(MAX_WAYS)-1:0]   cfg_ways,
  input  logic                          in_valid,
  input  logic [7:0]                    in_data,
  input  logic                          in_last,
  output logic                          in_ready,
  output logic                          out_valid,
  output logic [7:0]                    out_data,
  output logic                          out_chk,
  output logic                          out_last
);
  localparam int WW    = $clog2(MAX_WAYS);
  localparam int NSTG  = 8;
  localparam int CW    = $clog2(MAX_WAYS * NSTG + 1);

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [63:0] gpoly(input int c);
    logic [8:0][7:0] g;
    logic [7:0] root;
    g = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < c; i++) begin
      for (int j = 8; j > 0; j--) g[j] = g[j-1] ^ gmul(root, g[j]);
      g[0] = gmul(root, g[0]);
      root = gmul(root, 8'h02);
    end
    return g[7:0];
  endfunction

  localparam logic [63:0] G2 = gpoly(2);
  localparam logic [63:0] G3 = gpoly(3);
  localparam logic [63:0] G4 = gpoly(4);
  localparam logic [63:0] G6 = gpoly(6);
  localparam logic [63:0] G8 = gpoly(8);

  logic          act, emit;
  logic [2:0]    sel_q;
  logic [WW-1:0] dep_q, way;
  logic [CW-1:0] left;
  logic [7:0]    p [MAX_WAYS][NSTG];

  logic [2:0]    sel_e, tix;
  logic [WW-1:0] dep_e, way_nx;
  logic [63:0]   coef;
  logic [7:0]    top, fb;

  wire take  = in_valid && in_ready;
  wire start = take && !act;

  assign in_ready = !emit;
  assign sel_e    = act ? sel_q : cfg_chk_sel;
  assign dep_e    = act ? dep_q : cfg_ways;
  assign way_nx   = (way == dep_e) ? '0 : way + 1'b1;

  always_comb begin
    case (sel_e)
      3'd0:    begin tix = 3'd1; coef = G2; end
      3'd1:    begin tix = 3'd2; coef = G3; end
      3'd2:    begin tix = 3'd3; coef = G4; end
      3'd3:    begin tix = 3'd5; coef = G6; end
      default: begin tix = 3'd7; coef = G8; end
    endcase
  end

  assign top = start ? 8'h00 : p[way][tix];
  assign fb  = in_data ^ top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act       <= 1'b0;
      emit      <= 1'b0;
      sel_q     <= '0;
      dep_q     <= '0;
      way       <= '0;
      left      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chk   <= 1'b0;
      out_last  <= 1'b0;
      for (int w = 0; w < MAX_WAYS; w++)
        for (int j = 0; j < NSTG; j++) p[w][j] <= '0;
    end else begin
      out_valid <= take || emit;
      out_chk   <= emit;
      out_last  <= emit && (left == '0);
      out_data  <= emit ? top : in_data;
      if (start) begin
        act   <= 1'b1;
        sel_q <= cfg_chk_sel;
        dep_q <= cfg_ways;
      end
      if (take || emit) way <= way_nx;
      if (take && in_last) begin
        emit <= 1'b1;
        left <= CW'((32'(dep_e) + 1) * (32'(tix) + 1) - 1);
      end
      if (emit) begin
        if (left == '0) begin
          emit <= 1'b0;
          act  <= 1'b0;
        end else begin
          left <= left - 1'b1;
        end
      end
      for (int w = 0; w < MAX_WAYS; w++) begin
        for (int j = 0; j < NSTG; j++) begin
          if (w == int'(way) && take) begin
            if (j > int'(tix))
              p[w][j] <= '0;
            else
              p[w][j] <= ((j == 0 || start) ? 8'h00 : p[w][j-1]) ^ gmul(fb, coef[8*j +: 8]);
          end else if (w == int'(way) && emit) begin
            p[w][j] <= (j == 0 || j > int'(tix)) ? 8'h00 : p[w][j-1];
          end else if (start) begin
            p[w][j] <= '0;
          end
        end
      end
    end
  end

  assert_whole_rows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |-> (way == dep_e));
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> ($stable(sel_q) && $stable(dep_q)));
  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |=> (!in_ready && out_valid && !out_chk));
  assert_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_chk && !out_last) |=> (out_valid && out_chk));
  assert_last_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_chk));
  assert_last_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!out_chk && in_ready));
endmodule

// File: tb/rs_interleave_enc_test.sv
`timescale 1ns/1ps
module rs_interleave_enc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_chk_sel = '0;
  logic [1:0] cfg_ways = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_ready, out_valid, out_chk, out_last;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  int obs_n = 0;
  logic [7:0] obs_d [1100];
  bit         obs_c [1100];
  bit         obs_l [1100];
  logic [7:0] dat   [1100];

  always #2.5 clk = ~clk;

  rs_interleave_enc #(.MAX_WAYS(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_chk_sel(cfg_chk_sel), .cfg_ways(cfg_ways),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_chk(out_chk), .out_last(out_last));

  always @(negedge clk) begin
    if (rst_n && mon_on && out_valid && obs_n < 1100) begin
      obs_d[obs_n] = out_data;
      obs_c[obs_n] = out_chk;
      obs_l[obs_n] = out_last;
      obs_n++;
    end
  end

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    end
    return r;
  endfunction

  function automatic int cmap(input int sel);
    case (sel)
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_block(input int sel, input int dc, input int len, input int seed);
    int c = cmap(sel);
    int d = dc + 1;
    int total = d * len;
    int i = 0;
    int lowcnt = 0;
    int bad = 0;
    bit rdy;
    bit draining = 1'b1;
    for (int k = 0; k < total; k++) dat[k] = 8'((seed * 29 + k * k * 7 + k * 3 + 1) & 255);
    obs_n = 0;
    mon_on = 1'b1;
    while (i < total) begin
      @(negedge clk);
      rdy = in_ready;
      in_valid = 1'b1;
      in_data = dat[i];
      in_last = (i == total - 1);
      cfg_chk_sel = (i == 0) ? 3'(sel) : 3'(sel + i);
      cfg_ways    = (i == 0) ? 2'(dc) : 2'(dc + i);
      @(posedge clk);
      if (rdy) i++;
    end
    while (draining) begin
      @(negedge clk);
      if (in_ready) begin
        draining = 1'b0;
        in_valid = 1'b0;
        in_last = 1'b0;
      end else begin
        lowcnt++;
        in_valid = 1'b1;
        in_data = 8'hA5;
        in_last = 1'b1;
      end
    end
    repeat (2) @(negedge clk);
    mon_on = 1'b0;
    check(lowcnt == d * c, "R7", "ready-low cycles", lowcnt, d * c);
    check(obs_n == total + d * c, "R4", "output byte count", obs_n, total + d * c);
    if (obs_n == total + d * c) begin
      bad = 0;
      for (int k = 0; k < total; k++) if (obs_c[k] || obs_d[k] !== dat[k]) bad++;
      check(bad == 0, "R2", "pass-through mismatches", bad, 0);
      bad = 0;
      for (int k = total; k < obs_n; k++) if (!obs_c[k]) bad++;
      for (int k = 0; k < obs_n; k++) if (obs_l[k] != (k == obs_n - 1)) bad++;
      check(bad == 0, "R8", "chk/last flag errors", bad, 0);
      for (int w = 0; w < d; w++) begin
        logic [7:0] root = 8'h01;
        bad = 0;
        for (int r = 0; r < c; r++) begin
          logic [7:0] s = 8'h00;
          for (int k = 0; k < len; k++) s = fmul(s, root) ^ dat[k * d + w];
          for (int k = 0; k < c; k++) s = fmul(s, root) ^ obs_d[total + k * d + w];
          if (s != 0) bad++;
          root = fmul(root, 8'h02);
        end
        check(bad == 0, "R3 R5 R6", "nonzero syndromes", bad, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_chk == 1'b0 && out_last == 1'b0, "R1", "outputs in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "ready after reset", int'(in_ready), 1);
    for (int sel = 0; sel < 8; sel++)
      for (int dc = 0; dc < 4; dc++) begin
        run_block(sel, dc, 1, sel * 4 + dc);
        run_block(sel, dc, 5, sel * 7 + dc + 3);
      end
    run_block(0, 3, 253, 11);
    run_block(4, 0, 247, 12);
    run_block(3, 1, 249, 13);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule